// File: doc/BRIEF.md
# Load Bus-Cycle Sequencer

This block steps through the bus cycles that a single-register load takes in a pipelined core. For every clock of the load it says where the address comes from and what kind of transfer the bus carries. The address can come from the data address, the sequential fetch address, or a freshly loaded branch target. The transfer is internal (idle), non-sequential or sequential. Address arithmetic, memory and register write-back are handled elsewhere. The sequencer only names the source and the transfer kind, and it marks the cycle in which the load data comes back.

A load is launched by a one-cycle start strobe while the sequencer is idle. The same strobe carries three qualifiers: the address uses a scaled register offset, the destination is the program counter, and a single-cycle interlock stall applies. These qualifiers add internal cycles in fixed places. A load to the program counter ends with a non-sequential fetch of the new target and then two sequential refill fetches. The last cycle of every sequence raises a done pulse, and the sequencer is idle again on the next clock.

Top module: `load_cycle_seq`

## Requirements
- R1: Out of reset, and whenever no load is in progress, the outputs are address source FETCH (`addr_sel_o`=01), transfer INTERNAL (`trans_o`=00), `capture_o`=0 and `done_o`=0. The address source codes are DATA=00, FETCH=01 and TARGET=10. The transfer codes are INTERNAL=00, NONSEQ=10 and SEQ=11.
- R2: A plain load (no qualifiers) takes two cycles, DATA/NONSEQ followed by FETCH/NONSEQ.
- R3: With a scaled offset, one FETCH/INTERNAL cycle comes before the DATA/NONSEQ cycle. A plain scaled load is therefore FETCH/INTERNAL, DATA/NONSEQ, FETCH/NONSEQ.
- R4: A load to the program counter is DATA/NONSEQ, FETCH/INTERNAL, TARGET/NONSEQ, TARGET/SEQ, TARGET/SEQ.
- R5: A scaled load to the program counter takes six cycles: FETCH/INTERNAL followed by the five cycles of R4.
- R6: With the interlock qualifier, the cycle after the data access becomes FETCH/INTERNAL, and one extra FETCH/NONSEQ cycle ends the load. A scaled load with an interlock has the R3 prefix in front of this.
- R7: The interlock qualifier has no effect on a load to the program counter. Its sequence is the same as R4 or R5.
- R8: `capture_o` is high in exactly one cycle per load: the cycle right after the DATA/NONSEQ cycle.
- R9: `done_o` is high for exactly one cycle, the last cycle of the sequence. The cycle after it shows the idle outputs of R1.
- R10: A start strobe that arrives while a load is in progress, including in its done cycle, is ignored. The qualifiers are sampled only with an accepted start.
- R11: The first cycle of a sequence appears on the outputs one clock after the start strobe is sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start strobe for one load |
| scaled_i | input | 1 | Load uses scaled register offset addressing |
| pc_dest_i | input | 1 | Load destination is the program counter |
| interlock_i | input | 1 | A single-cycle interlock stall applies to this load |
| addr_sel_o | output | 2 | Address source: 00 data, 01 fetch, 10 branch target |
| trans_o | output | 2 | Transfer type: 00 internal, 10 non-sequential, 11 sequential |
| capture_o | output | 1 | Load data is returned in this cycle |
| done_o | output | 1 | Last cycle of the load sequence |

## Verification
The bench runs all eight qualifier combinations and compares every cycle against a sequence it builds from the rules above. A design that puts the scaled-offset internal cycle after the data access, or that lets the interlock stretch a program-counter load, would show a wrong transfer code in a specific cycle. The bench sends extra start strobes in the first and in the last cycle of a load, with the qualifiers inverted. A design that re-arms while busy would then lengthen the sequence or change its shape. The bench also checks that the capture pulse lands exactly one cycle after the data access and that done is followed by a clean idle cycle, so an off-by-one in either pulse is caught.

// File: rtl/load_cycle_seq_pkg.sv
package load_cycle_seq_pkg;

  typedef enum logic [3:0] {
    ST_IDLE   = 4'd0,
    ST_PRE    = 4'd1,
    ST_DACC   = 4'd2,
    ST_FCH_N  = 4'd3,
    ST_STALL  = 4'd4,
    ST_FCH_RE = 4'd5,
    ST_PC_I   = 4'd6,
    ST_TGT_N  = 4'd7,
    ST_TGT_S1 = 4'd8,
    ST_TGT_S2 = 4'd9
  } step_e;

  localparam int NUM_STEPS = 10;
  localparam int STEP_W    = 4;

  typedef enum logic [1:0] {
    SEL_DATA   = 2'b00,
    SEL_FETCH  = 2'b01,
    SEL_TARGET = 2'b10
  } addr_sel_e;

  typedef enum logic [1:0] {
    TR_INT  = 2'b00,
    TR_NSEQ = 2'b10,
    TR_SEQ  = 2'b11
  } trans_e;

  typedef struct packed {
    logic scaled;
    logic pc_dest;
    logic ilk;
  } ld_cfg_t;

endpackage

// File: rtl/lcs_rst_sync.sv
module lcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/lcs_step_next.sv
module lcs_step_next
  import load_cycle_seq_pkg::*;
(
  input  step_e   cur,
  input  logic    start,
  input  ld_cfg_t cfg_live,
  input  ld_cfg_t cfg_held,
  output step_e   nxt,
  output logic    accept
);
  always_comb begin
    accept = 1'b0;
    nxt    = cur;
    unique case (cur)
      ST_IDLE: begin
        if (start) begin
          accept = 1'b1;
          nxt    = cfg_live.scaled ? ST_PRE : ST_DACC;
        end
      end
      ST_PRE:    nxt = ST_DACC;
      ST_DACC: begin
        if (cfg_held.pc_dest)  nxt = ST_PC_I;
        else if (cfg_held.ilk) nxt = ST_STALL;
        else                   nxt = ST_FCH_N;
      end
      ST_FCH_N:  nxt = ST_IDLE;
      ST_STALL:  nxt = ST_FCH_RE;
      ST_FCH_RE: nxt = ST_IDLE;
      ST_PC_I:   nxt = ST_TGT_N;
      ST_TGT_N:  nxt = ST_TGT_S1;
      ST_TGT_S1: nxt = ST_TGT_S2;
      ST_TGT_S2: nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end
endmodule

// File: rtl/lcs_state_reg.sv
module lcs_state_reg
  import load_cycle_seq_pkg::*;
#(
  parameter bit ONE_HOT = 1'b1
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  step_e nxt,
  output step_e cur
);
  generate
    if (ONE_HOT) begin : g_onehot
      logic [NUM_STEPS-1:0] oh_q;
      logic [NUM_STEPS-1:0] oh_d;

      always_comb begin
        oh_d = '0;
        oh_d[int'(nxt)] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  oh_q <= NUM_STEPS'(1);
        else if (en) oh_q <= oh_d;
      end

      always_comb begin
        cur = ST_IDLE;
        for (int i = 0; i < NUM_STEPS; i++) begin
          if (oh_q[i]) cur = step_e'(STEP_W'(i));
        end
      end
    end else begin : g_binary
      step_e bin_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  bin_q <= ST_IDLE;
        else if (en) bin_q <= nxt;
      end

      assign cur = bin_q;
    end
  endgenerate
endmodule

// File: rtl/lcs_out_decode.sv
module lcs_out_decode
  import load_cycle_seq_pkg::*;
(
  input  step_e     cur,
  output addr_sel_e sel,
  output trans_e    trans,
  output logic      capture,
  output logic      done,
  output logic      busy
);
  always_comb begin
    sel     = SEL_FETCH;
    trans   = TR_INT;
    capture = 1'b0;
    done    = 1'b0;
    busy    = (cur != ST_IDLE);
    unique case (cur)
      ST_IDLE:   ;
      ST_PRE:    ;
      ST_DACC: begin
        sel   = SEL_DATA;
        trans = TR_NSEQ;
      end
      ST_FCH_N: begin
        trans   = TR_NSEQ;
        capture = 1'b1;
        done    = 1'b1;
      end
      ST_STALL:  capture = 1'b1;
      ST_FCH_RE: begin
        trans = TR_NSEQ;
        done  = 1'b1;
      end
      ST_PC_I:   capture = 1'b1;
      ST_TGT_N: begin
        sel   = SEL_TARGET;
        trans = TR_NSEQ;
      end
      ST_TGT_S1: begin
        sel   = SEL_TARGET;
        trans = TR_SEQ;
      end
      ST_TGT_S2: begin
        sel   = SEL_TARGET;
        trans = TR_SEQ;
        done  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/load_cycle_seq.sv
module load_cycle_seq
  import load_cycle_seq_pkg::*;
#(
  parameter bit ONE_HOT_STATE   = 1'b1,
  parameter int RST_SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic       scaled_i,
  input  logic       pc_dest_i,
  input  logic       interlock_i,
  output logic [1:0] addr_sel_o,
  output logic [1:0] trans_o,
  output logic       capture_o,
  output logic       done_o
);
  logic      rst_n_int;
  step_e     cur, nxt;
  logic      accept, busy, step_en;
  ld_cfg_t   cfg_live, cfg_q;
  addr_sel_e sel;
  trans_e    trans;

  lcs_rst_sync #(.STAGES(RST_SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  assign cfg_live = '{scaled: scaled_i, pc_dest: pc_dest_i, ilk: interlock_i};

  lcs_step_next u_next (
    .cur      (cur),
    .start    (start_i),
    .cfg_live (cfg_live),
    .cfg_held (cfg_q),
    .nxt      (nxt),
    .accept   (accept)
  );

  assign step_en = busy | accept;

  lcs_state_reg #(.ONE_HOT(ONE_HOT_STATE)) u_state (
    .clk   (clk),
    .rst_n (rst_n_int),
    .en    (step_en),
    .nxt   (nxt),
    .cur   (cur)
  );

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int)  cfg_q <= '0;
    else if (accept) cfg_q <= cfg_live;
  end

  lcs_out_decode u_dec (
    .cur     (cur),
    .sel     (sel),
    .trans   (trans),
    .capture (capture_o),
    .done    (done_o),
    .busy    (busy)
  );

  assign addr_sel_o = sel;
  assign trans_o    = trans;
endmodule

// File: rtl/load_cycle_seq_chk.sv
module load_cycle_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] addr_sel_o,
  input logic [1:0] trans_o,
  input logic       capture_o,
  input logic       done_o
);
  logic active_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    active_q <= 1'b0;
    else if (start_i && !active_q) active_q <= 1'b1;
    else if (done_o)               active_q <= 1'b0;
  end

  // R1: the transfer code is one of the three legal encodings
  p_legal_trans_r1: assert property (@(posedge clk) disable iff (!rst_n)
    trans_o != 2'b01);

  // R8: the data access is followed by the capture cycle
  p_capture_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_sel_o == 2'b00 && trans_o == 2'b10) |=> capture_o);

  // R9: done is followed by the idle outputs
  p_idle_after_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (trans_o == 2'b00 && addr_sel_o == 2'b01 && !capture_o && !done_o));

  // R11: an accepted start opens with a data access or a prefix internal cycle
  p_first_cycle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !active_q) |=>
      ((addr_sel_o == 2'b00 && trans_o == 2'b10) ||
       (addr_sel_o == 2'b01 && trans_o == 2'b00)));

  // R4: the target fetch is followed by a sequential refill from the target
  p_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_sel_o == 2'b10 && trans_o == 2'b10) |=> (addr_sel_o == 2'b10 && trans_o == 2'b11));

  // R8: capture never sits in the same cycle as a data access
  p_capture_apart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_o |-> addr_sel_o != 2'b00);
endmodule

bind load_cycle_seq load_cycle_seq_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .addr_sel_o (addr_sel_o),
  .trans_o    (trans_o),
  .capture_o  (capture_o),
  .done_o     (done_o)
);

// File: tb/load_cycle_seq_test.sv
`timescale 1ns/1ps
module load_cycle_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0, scaled_i = 1'b0, pc_dest_i = 1'b0, interlock_i = 1'b0;
  logic [1:0] addr_sel_o, trans_o;
  logic       capture_o, done_o;

  int n_vec = 0;
  int n_bad = 0;

  localparam logic [1:0] A_DATA = 2'b00, A_FETCH = 2'b01, A_TGT = 2'b10;
  localparam logic [1:0] T_I = 2'b00, T_N = 2'b10, T_S = 2'b11;

  logic [1:0] e_sel [8];
  logic [1:0] e_tr  [8];
  logic       e_cap [8];
  logic       e_done[8];
  int         e_len;

  always #2.5 clk = ~clk;

  load_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .scaled_i(scaled_i),
    .pc_dest_i(pc_dest_i), .interlock_i(interlock_i),
    .addr_sel_o(addr_sel_o), .trans_o(trans_o),
    .capture_o(capture_o), .done_o(done_o)
  );

  task automatic push(input logic [1:0] s, input logic [1:0] t, input logic c, input logic d);
    e_sel[e_len] = s; e_tr[e_len] = t; e_cap[e_len] = c; e_done[e_len] = d;
    e_len++;
  endtask

  // expected sequence composed from R2..R9
  task automatic build(input logic sc, input logic pc, input logic il);
    e_len = 0;
    if (sc) push(A_FETCH, T_I, 1'b0, 1'b0);           // R3 prefix
    push(A_DATA, T_N, 1'b0, 1'b0);
    if (pc) begin                                     // R4, R5, R7
      push(A_FETCH, T_I, 1'b1, 1'b0);
      push(A_TGT,   T_N, 1'b0, 1'b0);
      push(A_TGT,   T_S, 1'b0, 1'b0);
      push(A_TGT,   T_S, 1'b0, 1'b1);
    end else if (il) begin                            // R6
      push(A_FETCH, T_I, 1'b1, 1'b0);
      push(A_FETCH, T_N, 1'b0, 1'b1);
    end else begin                                    // R2
      push(A_FETCH, T_N, 1'b1, 1'b1);
    end
  endtask

  task automatic check(input string req, input logic [1:0] s, input logic [1:0] t,
                       input logic c, input logic d);
    n_vec++;
    if (addr_sel_o !== s || trans_o !== t || capture_o !== c || done_o !== d) begin
      n_bad++;
      $display("FAIL %s: got sel=%b tr=%b cap=%b done=%b, expected sel=%b tr=%b cap=%b done=%b",
               req, addr_sel_o, trans_o, capture_o, done_o, s, t, c, d);
    end
  endtask

  // inj_k: cycle index in which a stray start (inverted flags) is driven, -1 none
  task automatic run_load(input logic sc, input logic pc, input logic il, input int inj_k);
    build(sc, pc, il);
    start_i = 1'b1; scaled_i = sc; pc_dest_i = pc; interlock_i = il;
    @(negedge clk);
    start_i = 1'b0; scaled_i = ~sc; pc_dest_i = ~pc; interlock_i = ~il;
    for (int k = 0; k < e_len; k++) begin
      // R11 first cycle; R2..R9 per step
      check($sformatf("R2-seq R11 sc=%0b pc=%0b il=%0b step=%0d R8 R9", sc, pc, il, k),
            e_sel[k], e_tr[k], e_cap[k], e_done[k]);
      start_i = (k == inj_k);
      @(negedge clk);
    end
    start_i = 1'b0;
    // R9 idle after done; R10 stray start had no effect
    check((inj_k >= 0) ? "R10 stray start ignored" : "R9 idle after done",
          A_FETCH, T_I, 1'b0, 1'b0);
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", A_FETCH, T_I, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after reset", A_FETCH, T_I, 1'b0, 1'b0);

    for (int v = 0; v < 8; v++) begin
      run_load(v[2], v[1], v[0], -1);
    end
    for (int v = 0; v < 8; v++) begin
      run_load(v[2], v[1], v[0], 0);
    end
    for (int v = 0; v < 8; v++) begin
      build(v[2], v[1], v[0]);
      run_load(v[2], v[1], v[0], e_len - 1);
    end

    // R10: back-to-back, a start in the idle cycle after done is accepted
    run_load(1'b0, 1'b0, 1'b0, -1);
    run_load(1'b1, 1'b1, 1'b1, -1);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule